// File: doc/BRIEF.md
# Data-width bridging adapter

This block joins a Wishbone-classic master of one data width to a slave of another width, in either direction: a narrow master onto a wide slave (up-sizing) or a wide master onto a narrow slave (down-sizing). It has no clock, no reset and no storage. Every output is a combinational function of the present inputs, so an access crosses it in the same cycle.

For each access the adapter rewrites the address for the slave. It drives the slave byte selects so that they cover exactly the bytes being accessed, and it steers the data lanes in both directions. Access granularity stays at 8 bits, and one access never becomes more than one slave access. A parameter chooses whether a lower address lands on a lower-numbered byte lane (little-endian) or a higher-numbered one (big-endian).

The response side follows a daisy-chain convention, so several slaves can share one return path without a central multiplexer. While the master strobe is high, the master sees the slave's response. While it is low, the master sees the values on the chain inputs fed from the previous slave in the chain.

Top module: `bus_resize`

## Requirements
- R1: Cycle, strobe and write-enable reach the slave port unchanged.
- R2: While `mStb` is 1, `mAck`, `mRty` and `mErr` equal `sAck`, `sRty` and `sErr`, and `mDatO` carries slave read data as described in R7, R10 and R11.
- R3: While `mStb` is 0, `mAck`, `mRty`, `mErr` and `mDatO` equal `ackChain`, `rtyChain`, `errChain` and `datChain`.
- R4: Up-sizing by ratio N: `sAdr` is `mAdr` with its low log2(N) bits removed.
- R5: Up-sizing, little-endian: the lane index is the low log2(N) address bits, and `sSel` is `mSel` shifted up by lane×(master bytes). For 16 to 32 bits, an even address drives `sSel[1:0]` and an odd address drives `sSel[3:2]`.
- R6: Up-sizing, big-endian: the lane index is N−1 minus the low address bits. For 16 to 32 bits, an even address drives `sSel[3:2]` and an odd address drives `sSel[1:0]`.
- R7: Up-sizing: `sDatO` holds `mDatI` repeated in every lane, and `mDatO` is the slave lane given by the lane index.
- R8: Down-sizing: the master word is cut into N slices, with slice k being bits [k·S +: S]. The slice chosen is the lowest-numbered slice that has any byte select set (little-endian) or the highest-numbered one (big-endian). With no select set, the slice at sub-address 0 is used: slice 0 for little-endian, slice N−1 for big-endian.
- R9: Down-sizing: `sAdr` is `{mAdr, sub}`, where sub is the slice index (little-endian) or N−1 minus the slice index (big-endian).
- R10: Down-sizing: `sSel` and `sDatO` are the chosen slice of `mSel` and `mDatI`, and `mDatO` is `sDatI` repeated in every slice.
- R11: With equal widths, address, selects and data pass straight through in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mCyc | input | 1 | Master bus cycle frame |
| mStb | input | 1 | Master strobe; selects this adapter |
| mWe | input | 1 | Master write enable |
| mAdr | input | MST_AW | Master word address |
| mSel | input | MST_DW/8 | Master byte selects |
| mDatI | input | MST_DW | Write data from the master |
| mDatO | output | MST_DW | Read data to the master (chain-gated) |
| mAck | output | 1 | Acknowledge to the master (chain-gated) |
| mRty | output | 1 | Retry to the master (chain-gated) |
| mErr | output | 1 | Error to the master (chain-gated) |
| ackChain | input | 1 | Acknowledge from the previous chain member |
| rtyChain | input | 1 | Retry from the previous chain member |
| errChain | input | 1 | Error from the previous chain member |
| datChain | input | MST_DW | Read data from the previous chain member |
| sCyc | output | 1 | Slave cycle frame |
| sStb | output | 1 | Slave strobe |
| sWe | output | 1 | Slave write enable |
| sAdr | output | SLV_AW | Slave word address |
| sSel | output | SLV_DW/8 | Slave byte selects |
| sDatO | output | SLV_DW | Write data to the slave |
| sDatI | input | SLV_DW | Read data from the slave |
| sAck | input | 1 | Slave acknowledge |
| sRty | input | 1 | Slave retry |
| sErr | input | 1 | Slave error |

## Verification
The bench builds five copies side by side:
- 16-bit master to 32-bit slave, little-endian and big-endian;
- 32-bit master to 16-bit slave, little-endian and big-endian;
- 32 bits to 32 bits.

Each of the three generate branches is therefore elaborated and driven. Running both endian settings against the same master stimulus exposes any swap of lane order. In the down-size copies, the select patterns that reach both slices, only one slice, or neither slice exercise the priority and default rules of the slice choice.

// File: rtl/bus_resize_pkg.sv
package bus_resize_pkg;
  // Steering strobes handed from the control to the datapath
  typedef struct packed {
    logic       fromSlave;  // respond with slave values, not chain values
    logic [7:0] lane;       // lane index (up-size) or slice index (down-size)
  } steerT;
endpackage

// File: rtl/bus_resize_ctrl.sv
module bus_resize_ctrl
  import bus_resize_pkg::*;
#(
  parameter int MST_DW = 16,
  parameter int SLV_DW = 32,
  parameter int MST_AW = 8,
  parameter int SLV_AW = 7,
  parameter bit LITTLE = 1'b1
) (
  input  logic                mStb,
  input  logic [MST_AW-1:0]   mAdr,
  input  logic [MST_DW/8-1:0] mSel,
  output logic [SLV_AW-1:0]   sAdr,
  output logic [SLV_DW/8-1:0] sSel,
  output steerT               steer
);
  localparam int MB = MST_DW / 8;
  localparam int SB = SLV_DW / 8;

  generate
    if (MST_DW < SLV_DW) begin : gUp
      localparam int R  = SLV_DW / MST_DW;
      localparam int SH = $clog2(R);
      logic [SH-1:0] idx;
      int            laneI;
      logic [R-1:0]  laneHit;

      assign idx  = mAdr[SH-1:0];
      assign sAdr = mAdr[MST_AW-1:SH];

      always_comb begin
        laneI = LITTLE ? int'(idx) : (R - 1 - int'(idx));
        sSel  = SB'(mSel) << (laneI * MB);
        steer.fromSlave = mStb;
        steer.lane      = 8'(laneI);
      end

      always_comb begin
        for (int k = 0; k < R; k++) laneHit[k] = |sSel[k*MB +: MB];
        AST_SEL_KEPT: assert ($countones(sSel) == $countones(mSel)) else $error("select bits lost"); // R5
        AST_ONE_LANE: assert ($onehot0(laneHit)) else $error("selects spread over lanes"); // R6
      end
    end else if (MST_DW > SLV_DW) begin : gDown
      localparam int R  = MST_DW / SLV_DW;
      localparam int SH = $clog2(R);
      int slice;
      int sub;

      always_comb begin
        slice = LITTLE ? 0 : R - 1;
        if (LITTLE) begin
          for (int k = R - 1; k >= 0; k--)
            if (|mSel[k*SB +: SB]) slice = k;
        end else begin
          for (int k = 0; k < R; k++)
            if (|mSel[k*SB +: SB]) slice = k;
        end
        sub  = LITTLE ? slice : (R - 1 - slice);
        sAdr = {mAdr, SH'(sub)};
        sSel = SB'(mSel >> (slice * SB));
        steer.fromSlave = mStb;
        steer.lane      = 8'(slice);
      end

      always_comb begin
        AST_SEL_NONEMPTY: assert (!(|mSel) || (|sSel)) else $error("selected access lost"); // R8
      end
    end else begin : gEq
      assign sAdr = SLV_AW'(mAdr);
      assign sSel = SB'(mSel);
      assign steer.fromSlave = mStb;
      assign steer.lane      = 8'd0;
    end
  endgenerate
endmodule

// File: rtl/bus_resize_dp.sv
module bus_resize_dp
  import bus_resize_pkg::*;
#(
  parameter int MST_DW = 16,
  parameter int SLV_DW = 32
) (
  input  steerT               steer,
  input  logic [SLV_DW/8-1:0] sSel,
  input  logic [MST_DW-1:0]   mDatI,
  input  logic [SLV_DW-1:0]   sDatI,
  input  logic                sAck,
  input  logic                sRty,
  input  logic                sErr,
  input  logic                ackChain,
  input  logic                rtyChain,
  input  logic                errChain,
  input  logic [MST_DW-1:0]   datChain,
  output logic [SLV_DW-1:0]   sDatO,
  output logic [MST_DW-1:0]   mDatO,
  output logic                mAck,
  output logic                mRty,
  output logic                mErr
);
  localparam int MB = MST_DW / 8;
  logic [MST_DW-1:0] rdData;

  generate
    if (MST_DW < SLV_DW) begin : gUp
      localparam int R = SLV_DW / MST_DW;
      assign sDatO  = {R{mDatI}};
      assign rdData = MST_DW'(sDatI >> (int'(steer.lane) * MST_DW));

      always_comb begin
        for (int b = 0; b < SLV_DW / 8; b++)
          if (sSel[b])
            AST_WR_LANE: assert (sDatO[b*8 +: 8] == mDatI[(b % MB)*8 +: 8]) else $error("write lane mismatch"); // R7
      end
    end else if (MST_DW > SLV_DW) begin : gDown
      localparam int R = MST_DW / SLV_DW;
      assign sDatO  = SLV_DW'(mDatI >> (int'(steer.lane) * SLV_DW));
      assign rdData = {R{sDatI}};
    end else begin : gEq
      assign sDatO  = SLV_DW'(mDatI);
      assign rdData = MST_DW'(sDatI);
    end
  endgenerate

  // Daisy-chain gating of the response path
  always_comb begin
    if (steer.fromSlave) begin
      mAck = sAck; mRty = sRty; mErr = sErr; mDatO = rdData;
    end else begin
      mAck = ackChain; mRty = rtyChain; mErr = errChain; mDatO = datChain;
    end
  end

  always_comb begin
    AST_RSP_EXCL: assert (!(steer.fromSlave && !sAck && !sRty && !sErr) || !(mAck || mRty || mErr))
      else $error("response without slave response"); // R2
  end
endmodule

// File: rtl/bus_resize.sv
module bus_resize
  import bus_resize_pkg::*;
#(
  parameter int MST_DW = 16,
  parameter int SLV_DW = 32,
  parameter int MST_AW = 8,
  parameter bit LITTLE = 1'b1,
  localparam int RSH = (MST_DW < SLV_DW) ? $clog2(SLV_DW / MST_DW)
                     : (MST_DW > SLV_DW) ? $clog2(MST_DW / SLV_DW) : 0,
  localparam int SLV_AW = (MST_DW < SLV_DW) ? MST_AW - RSH : MST_AW + RSH
) (
  input  logic                mCyc,
  input  logic                mStb,
  input  logic                mWe,
  input  logic [MST_AW-1:0]   mAdr,
  input  logic [MST_DW/8-1:0] mSel,
  input  logic [MST_DW-1:0]   mDatI,
  output logic [MST_DW-1:0]   mDatO,
  output logic                mAck,
  output logic                mRty,
  output logic                mErr,
  input  logic                ackChain,
  input  logic                rtyChain,
  input  logic                errChain,
  input  logic [MST_DW-1:0]   datChain,
  output logic                sCyc,
  output logic                sStb,
  output logic                sWe,
  output logic [SLV_AW-1:0]   sAdr,
  output logic [SLV_DW/8-1:0] sSel,
  output logic [SLV_DW-1:0]   sDatO,
  input  logic [SLV_DW-1:0]   sDatI,
  input  logic                sAck,
  input  logic                sRty,
  input  logic                sErr
);
  steerT steer;

  assign sCyc = mCyc;
  assign sStb = mStb;
  assign sWe  = mWe;

  bus_resize_ctrl #(
    .MST_DW(MST_DW), .SLV_DW(SLV_DW), .MST_AW(MST_AW), .SLV_AW(SLV_AW), .LITTLE(LITTLE)
  ) uCtrl (
    .mStb(mStb), .mAdr(mAdr), .mSel(mSel), .sAdr(sAdr), .sSel(sSel), .steer(steer)
  );

  bus_resize_dp #(.MST_DW(MST_DW), .SLV_DW(SLV_DW)) uDp (
    .steer(steer), .sSel(sSel), .mDatI(mDatI), .sDatI(sDatI),
    .sAck(sAck), .sRty(sRty), .sErr(sErr),
    .ackChain(ackChain), .rtyChain(rtyChain), .errChain(errChain), .datChain(datChain),
    .sDatO(sDatO), .mDatO(mDatO), .mAck(mAck), .mRty(mRty), .mErr(mErr)
  );
endmodule

// File: tb/bus_resize_test.sv
module bus_resize_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // shared control and response inputs
  logic mCyc, mStb, mWe, sAck, sRty, sErr, ackChain, rtyChain, errChain;

  // 16-bit master copies
  logic [7:0]  upAdr;
  logic [1:0]  upSel;
  logic [15:0] upDatI, upChain;
  logic [31:0] upSDatI;
  logic [6:0]  uSAdr, bSAdr;
  logic [3:0]  uSSel, bSSel;
  logic [31:0] uSDatO, bSDatO;
  logic [15:0] uMDatO, bMDatO;
  logic uAck, uRty, uErr, uCyc, uStb, uWe;
  logic [5:0] bHs;

  // 32-bit master copies
  logic [7:0]  dnAdr;
  logic [3:0]  dnSel;
  logic [31:0] dnDatI, dnChain;
  logic [15:0] dnSDatI;
  logic [8:0]  lSAdr, gSAdr;
  logic [1:0]  lSSel, gSSel;
  logic [15:0] lSDatO, gSDatO;
  logic [31:0] lMDatO, gMDatO;
  logic [5:0]  lHs, gHs, eHs;
  logic [7:0]  eSAdr;
  logic [3:0]  eSSel;
  logic [31:0] eSDatO, eMDatO;

  bus_resize #(.MST_DW(16), .SLV_DW(32), .MST_AW(8), .LITTLE(1'b1)) uut (
    .mCyc(mCyc), .mStb(mStb), .mWe(mWe), .mAdr(upAdr), .mSel(upSel), .mDatI(upDatI),
    .mDatO(uMDatO), .mAck(uAck), .mRty(uRty), .mErr(uErr),
    .ackChain(ackChain), .rtyChain(rtyChain), .errChain(errChain), .datChain(upChain),
    .sCyc(uCyc), .sStb(uStb), .sWe(uWe), .sAdr(uSAdr), .sSel(uSSel), .sDatO(uSDatO),
    .sDatI(upSDatI), .sAck(sAck), .sRty(sRty), .sErr(sErr));

  bus_resize #(.MST_DW(16), .SLV_DW(32), .MST_AW(8), .LITTLE(1'b0)) uutUpBig (
    .mCyc(mCyc), .mStb(mStb), .mWe(mWe), .mAdr(upAdr), .mSel(upSel), .mDatI(upDatI),
    .mDatO(bMDatO), .mAck(bHs[0]), .mRty(bHs[1]), .mErr(bHs[2]),
    .ackChain(ackChain), .rtyChain(rtyChain), .errChain(errChain), .datChain(upChain),
    .sCyc(bHs[3]), .sStb(bHs[4]), .sWe(bHs[5]), .sAdr(bSAdr), .sSel(bSSel), .sDatO(bSDatO),
    .sDatI(upSDatI), .sAck(sAck), .sRty(sRty), .sErr(sErr));

  bus_resize #(.MST_DW(32), .SLV_DW(16), .MST_AW(8), .LITTLE(1'b1)) uutDnLit (
    .mCyc(mCyc), .mStb(mStb), .mWe(mWe), .mAdr(dnAdr), .mSel(dnSel), .mDatI(dnDatI),
    .mDatO(lMDatO), .mAck(lHs[0]), .mRty(lHs[1]), .mErr(lHs[2]),
    .ackChain(ackChain), .rtyChain(rtyChain), .errChain(errChain), .datChain(dnChain),
    .sCyc(lHs[3]), .sStb(lHs[4]), .sWe(lHs[5]), .sAdr(lSAdr), .sSel(lSSel), .sDatO(lSDatO),
    .sDatI(dnSDatI), .sAck(sAck), .sRty(sRty), .sErr(sErr));

  bus_resize #(.MST_DW(32), .SLV_DW(16), .MST_AW(8), .LITTLE(1'b0)) uutDnBig (
    .mCyc(mCyc), .mStb(mStb), .mWe(mWe), .mAdr(dnAdr), .mSel(dnSel), .mDatI(dnDatI),
    .mDatO(gMDatO), .mAck(gHs[0]), .mRty(gHs[1]), .mErr(gHs[2]),
    .ackChain(ackChain), .rtyChain(rtyChain), .errChain(errChain), .datChain(dnChain),
    .sCyc(gHs[3]), .sStb(gHs[4]), .sWe(gHs[5]), .sAdr(gSAdr), .sSel(gSSel), .sDatO(gSDatO),
    .sDatI(dnSDatI), .sAck(sAck), .sRty(sRty), .sErr(sErr));

  bus_resize #(.MST_DW(32), .SLV_DW(32), .MST_AW(8), .LITTLE(1'b1)) uutEq (
    .mCyc(mCyc), .mStb(mStb), .mWe(mWe), .mAdr(dnAdr), .mSel(dnSel), .mDatI(dnDatI),
    .mDatO(eMDatO), .mAck(eHs[0]), .mRty(eHs[1]), .mErr(eHs[2]),
    .ackChain(ackChain), .rtyChain(rtyChain), .errChain(errChain), .datChain(dnChain),
    .sCyc(eHs[3]), .sStb(eHs[4]), .sWe(eHs[5]), .sAdr(eSAdr), .sSel(eSSel), .sDatO(eSDatO),
    .sDatI(upSDatI), .sAck(sAck), .sRty(sRty), .sErr(sErr));

  typedef struct packed {
    logic [7:0] adr;
    logic [1:0] sel;
    logic [6:0] expAdr;
    logic [3:0] expSel;
  } vecT;

  // up-size address and select vectors for the little-endian copy (R4, R5)
  localparam vecT VECS [0:5] = '{
    '{8'h00, 2'b11, 7'h00, 4'b0011},
    '{8'h01, 2'b11, 7'h00, 4'b1100},
    '{8'h35, 2'b01, 7'h1A, 4'b0100},
    '{8'h34, 2'b10, 7'h1A, 4'b0010},
    '{8'hFF, 2'b10, 7'h7F, 4'b1000},
    '{8'h80, 2'b00, 7'h40, 4'b0000}
  };

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  initial begin
    mCyc = 0; mStb = 0; mWe = 0; sAck = 0; sRty = 0; sErr = 0;
    ackChain = 0; rtyChain = 0; errChain = 0;
    upAdr = 0; upSel = 0; upDatI = 0; upChain = 0; upSDatI = 0;
    dnAdr = 0; dnSel = 0; dnDatI = 0; dnChain = 0; dnSDatI = 0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    settle();
    // quiet state: no strobe, no response (R3)
    chk("R3 idle ack", {uAck, uRty, uErr}, 3'b000);
    chk("R1 idle strobe", {uCyc, uStb, uWe}, 3'b000);

    // vector walk (R4, R5, R6)
    mCyc = 1; mStb = 1;
    for (int i = 0; i < 6; i++) begin
      upAdr = VECS[i].adr; upSel = VECS[i].sel;
      settle();
      chk("R4 up address", uSAdr, VECS[i].expAdr);
      chk("R5 up little select", uSSel, VECS[i].expSel);
      chk("R4 up address big", bSAdr, VECS[i].expAdr);
      chk("R6 up big select", bSSel, VECS[i].adr[0] ? {2'b00, VECS[i].sel} : {VECS[i].sel, 2'b00});
    end

    // R1 pass-through of controls
    mWe = 1; settle();
    chk("R1 controls", {uCyc, uStb, uWe}, 3'b111);
    mCyc = 0; settle();
    chk("R1 cycle drop", {uCyc, uStb, uWe}, 3'b011);
    mCyc = 1;

    // R7 write replication and read lane
    upDatI = 16'hBEEF; upSDatI = 32'h1234_5678; upAdr = 8'h02; upSel = 2'b11;
    settle();
    chk("R7 write replicate", uSDatO, 32'hBEEF_BEEF);
    chk("R7 read even little", uMDatO, 16'h5678);
    chk("R7 read even big", bMDatO, 16'h1234);
    upAdr = 8'h03; settle();
    chk("R7 read odd little", uMDatO, 16'h1234);
    chk("R7 read odd big", bMDatO, 16'h5678);

    // R2 and R3 response gating
    sAck = 1; sRty = 0; sErr = 1; ackChain = 0; rtyChain = 1; errChain = 0; upChain = 16'hC0DE;
    settle();
    chk("R2 slave response", {uAck, uRty, uErr}, 3'b101);
    mStb = 0; settle();
    chk("R3 chain response", {uAck, uRty, uErr}, 3'b010);
    chk("R3 chain data", uMDatO, 16'hC0DE);
    dnChain = 32'hFACE_0001; settle();
    chk("R3 chain data down", lMDatO, 32'hFACE_0001);
    mStb = 1; sAck = 0; sErr = 0;

    // down-size (R8, R9, R10)
    dnAdr = 8'h5A; dnDatI = 32'hAAAA_5555; dnSDatI = 16'h9C3E;
    dnSel = 4'b1100; settle();
    chk("R8 little upper slice sel", lSSel, 2'b11);
    chk("R9 little upper slice adr", lSAdr, {8'h5A, 1'b1});
    chk("R10 little upper slice data", lSDatO, 16'hAAAA);
    chk("R9 big upper slice adr", gSAdr, {8'h5A, 1'b0});
    chk("R10 read replicate", lMDatO, 32'h9C3E_9C3E);
    dnSel = 4'b0011; settle();
    chk("R9 little lower slice adr", lSAdr, {8'h5A, 1'b0});
    chk("R10 little lower slice data", lSDatO, 16'h5555);
    chk("R9 big lower slice adr", gSAdr, {8'h5A, 1'b1});
    chk("R10 big lower slice data", gSDatO, 16'h5555);
    dnSel = 4'b0110; settle();
    chk("R8 little both slices", {lSAdr[0], lSSel}, 3'b010);
    chk("R8 big both slices", {gSAdr[0], gSSel}, 3'b001);
    dnSel = 4'b0000; settle();
    chk("R8 little none", {lSAdr[0], lSSel, lSDatO}, {3'b000, 16'h5555});
    chk("R8 big none", {gSAdr[0], gSSel, gSDatO}, {3'b000, 16'hAAAA});

    // R11 equal widths
    dnSel = 4'b1010; upSDatI = 32'h0BAD_F00D; settle();
    chk("R11 equal adr", eSAdr, 8'h5A);
    chk("R11 equal sel", eSSel, 4'b1010);
    chk("R11 equal wdata", eSDatO, 32'hAAAA_5555);
    chk("R11 equal rdata", eMDatO, 32'h0BAD_F00D);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule